// File: doc/BRIEF.md
# Pipelined Converter Stage-Code Correction

This block is the digital back end of a nine-stage pipelined analog-to-digital converter. Stages one to eight each resolve a 1.5-bit decision, a code of 0, 1 or 2. The last stage is a 2-bit flash with a code from 0 to 3. A held sample advances one stage per half clock period, so the code for one sample reaches the block spread over nine consecutive time slots. The block runs on a clock at the slot rate, which is twice the sample rate. It captures every stage's code in each slot and delays each one by a per-stage skew, so that all nine codes of a sample meet in the same slot. It then adds them with overlapping binary weights and registers the 10-bit result.

Because neighbouring stages overlap in weight, a comparator that trips early or late in one stage is absorbed by the stages after it. Every result from 0 to 1023 can be reached, and the same result comes out for several different decision patterns. A single strobe marks the slot in which stage one presents a new sample. A code of 3 from a 1.5-bit stage cannot occur in a healthy converter. The block counts it as 2 and raises a sticky error flag.

Top module: `adc_digital_corr`

## Requirements
- R1: While `rst` is high at a rising clock edge, the block clears every skew register, its pending strobes, `result_o` (to 0), `result_vld_o` and `code_err_o`; all three outputs read 0 after that edge.
- R2: For a sample whose stage codes are c1..c9, the result is the sum of ck·2^(9−k) for k = 1..8 plus c9. Stage k's code sits in bits [2k−1:2k−2] of `stage_codes_i`, so stage one occupies bits [1:0] and stage nine occupies bits [17:16].
- R3: When `smp_strobe_i` is high at edge j, `result_vld_o` is high for exactly one cycle, after edge j+9: ten slots, or five sample clocks. `result_vld_o` is never high without such a strobe.
- R4: The sample started at slot j uses stage k's code only from slot j+k−1. Codes presented in any other slot do not change that sample's result.
- R5: Different valid decision patterns for the same value give the same result, and every value 0..1023 is produced by at least one pattern.
- R6: A code of 3 from stage k (k ≤ 8) in a slot that belongs to a sample is added as 2. It sets `code_err_o` after the second rising edge counted from the slot in which it is presented, and the flag then stays high until reset.
- R7: A code of 3 on a stage lane in a slot that belongs to no sample does not set `code_err_o`.
- R8: A code of 3 from stage nine is legal and never sets `code_err_o`.
- R9: Between valid pulses, `result_o` keeps the last valid result (0 after reset).
- R10: Strobes in consecutive slots are accepted, and each yields its own correct result ten slots later.
- R11: A reset while samples are in flight discards them; no valid pulse for those samples appears afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock, twice the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| smp_strobe_i | input | 1 | High in the slot where stage one presents a new sample's code |
| stage_codes_i | input | 18 | Nine 2-bit stage codes, stage one in the low bits |
| result_o | output | 10 | Corrected, registered result |
| result_vld_o | output | 1 | One-cycle pulse when `result_o` holds a new sample |
| code_err_o | output | 1 | Sticky flag: illegal code seen in a 1.5-bit stage |

## Verification
Four properties are checked on every cycle: the ten-slot relation between strobe and valid pulse, the hold of the result between pulses, the sticky nature of the error flag, and the two-slot link between an owned illegal code and the flag rising. The arithmetic is shown only by the bench's scenarios. These are the weighted sum over all 1024 values under three decision policies, with the answer computed from the weights alone. The scenarios also cover immunity to junk codes in unowned slots, back-to-back strobes, clamping of a forced illegal code, and the flush of in-flight samples by reset.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;

    localparam int unsigned CODE_W = 2;

    typedef logic [CODE_W-1:0] stage_code_t;

    localparam stage_code_t CODE_BAD = 2'd3;
    localparam stage_code_t CODE_TOP = 2'd2;

    // Slots a stage code must wait so it meets the last stage's code.
    function automatic int unsigned skew_slots(input int unsigned n_stages,
                                               input int unsigned stage_idx);
        return n_stages - 1 - stage_idx;
    endfunction

    // Map an out-of-range redundant code onto the highest legal one.
    function automatic stage_code_t clamp_redundant(input stage_code_t c);
        return (c == CODE_BAD) ? CODE_TOP : c;
    endfunction

endpackage

// File: rtl/corr_lane_capture.sv
`timescale 1ns/1ps
module corr_lane_capture
    import adc_corr_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 9
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              strobe_i,
    input  logic [NUM_STAGES*CODE_W-1:0]      codes_i,
    output stage_code_t [NUM_STAGES-1:0]      lane_o,
    output logic                              aligned_o,
    output logic                              illegal_hit_o
);

    stage_code_t [NUM_STAGES-1:0] raw_q;
    logic        [NUM_STAGES-1:0] tag_q;   // tag_q[i]: strobe seen i slots before the captured slot
    logic        [NUM_STAGES-1:0] bad_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
            tag_q <= '0;
        end else begin
            raw_q <= codes_i;
            tag_q <= {tag_q[NUM_STAGES-2:0], strobe_i};
        end
    end

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_lane
        if (i < NUM_STAGES - 1) begin : g_redundant
            assign lane_o[i] = clamp_redundant(raw_q[i]);
            assign bad_w[i]  = (raw_q[i] == CODE_BAD);
        end else begin : g_flash
            assign lane_o[i] = raw_q[i];
            assign bad_w[i]  = 1'b0;
        end
    end

    assign illegal_hit_o = |(bad_w & tag_q);
    assign aligned_o     = tag_q[NUM_STAGES-1];

endmodule

// File: rtl/corr_skew_line.sv
`timescale 1ns/1ps
module corr_skew_line #(
    parameter int unsigned DEPTH = 1,
    parameter int unsigned WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [DEPTH-1:0][WIDTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else begin
            sr_q[0] <= d_i;
            for (int s = 1; s < int'(DEPTH); s++) begin
                sr_q[s] <= sr_q[s-1];
            end
        end
    end

    assign q_o = sr_q[DEPTH-1];

endmodule

// File: rtl/corr_weight_sum.sv
`timescale 1ns/1ps
module corr_weight_sum
    import adc_corr_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 9,
    localparam int unsigned OUT_W     = NUM_STAGES + 1
) (
    input  stage_code_t [NUM_STAGES-1:0] codes_i,
    output logic [OUT_W-1:0]             sum_o
);

    // Stage i (zero-based) carries weight 2^(NUM_STAGES-1-i); neighbours overlap by one bit.
    always_comb begin
        sum_o = '0;
        for (int i = 0; i < int'(NUM_STAGES); i++) begin
            sum_o = sum_o + (OUT_W'(codes_i[i]) << (int'(NUM_STAGES) - 1 - i));
        end
    end

endmodule

// File: rtl/adc_digital_corr.sv
`timescale 1ns/1ps
module adc_digital_corr
    import adc_corr_pkg::*;
#(
    parameter int unsigned NUM_STAGES = 9,
    localparam int unsigned OUT_W     = NUM_STAGES + 1,
    localparam int unsigned BUS_W     = NUM_STAGES * CODE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             smp_strobe_i,
    input  logic [BUS_W-1:0] stage_codes_i,
    output logic [OUT_W-1:0] result_o,
    output logic             result_vld_o,
    output logic             code_err_o
);

    stage_code_t [NUM_STAGES-1:0] lane_w;
    stage_code_t [NUM_STAGES-1:0] algn_w;
    logic                         aligned_w;
    logic                         hit_w;
    logic [OUT_W-1:0]             sum_w;

    corr_lane_capture #(.NUM_STAGES(NUM_STAGES)) u_capture (
        .clk           (clk),
        .rst           (rst),
        .strobe_i      (smp_strobe_i),
        .codes_i       (stage_codes_i),
        .lane_o        (lane_w),
        .aligned_o     (aligned_w),
        .illegal_hit_o (hit_w)
    );

    for (genvar i = 0; i < NUM_STAGES; i++) begin : g_skew
        if (skew_slots(NUM_STAGES, i) == 0) begin : g_direct
            assign algn_w[i] = lane_w[i];
        end else begin : g_delay
            corr_skew_line #(
                .DEPTH (skew_slots(NUM_STAGES, i)),
                .WIDTH (CODE_W)
            ) u_line (
                .clk (clk),
                .rst (rst),
                .d_i (lane_w[i]),
                .q_o (algn_w[i])
            );
        end
    end

    corr_weight_sum #(.NUM_STAGES(NUM_STAGES)) u_sum (
        .codes_i (algn_w),
        .sum_o   (sum_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o     <= '0;
            result_vld_o <= 1'b0;
            code_err_o   <= 1'b0;
        end else begin
            result_vld_o <= aligned_w;
            if (aligned_w) begin
                result_o <= sum_w;
            end
            code_err_o <= code_err_o | hit_w;
        end
    end

endmodule

// File: rtl/adc_digital_corr_chk.sv
`timescale 1ns/1ps
module adc_digital_corr_chk #(
    parameter int unsigned NUM_STAGES = 9,
    localparam int unsigned OUT_W     = NUM_STAGES + 1,
    localparam int unsigned BUS_W     = NUM_STAGES * 2,
    localparam int unsigned LAT       = NUM_STAGES + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_strobe_i,
    input logic [BUS_W-1:0] stage_codes_i,
    input logic [OUT_W-1:0] result_o,
    input logic             result_vld_o,
    input logic             code_err_o
);

    logic [LAT-1:0]        hist_q;
    logic [NUM_STAGES-1:0] own_now;
    logic                  owned_bad;
    logic                  rst_seen_q;

    always_ff @(posedge clk) begin
        if (rst) hist_q <= '0;
        else     hist_q <= {hist_q[LAT-2:0], smp_strobe_i};
        rst_seen_q <= rst;
    end

    assign own_now = {hist_q[NUM_STAGES-2:0], smp_strobe_i};

    always_comb begin
        owned_bad = 1'b0;
        for (int i = 0; i < int'(NUM_STAGES) - 1; i++) begin
            if (own_now[i] && stage_codes_i[2*i +: 2] == 2'd3) owned_bad = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_seen_q) begin
            assert_reset_state_R1: assert (result_o == '0 && !result_vld_o && !code_err_o);
        end
    end

    assert_vld_latency_R3: assert property (@(posedge clk) disable iff (rst)
        result_vld_o == hist_q[LAT-1]);

    assert_err_set_R6: assert property (@(posedge clk) disable iff (rst)
        owned_bad |-> ##2 code_err_o);

    assert_err_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        code_err_o |=> code_err_o);

    assert_err_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(code_err_o) |-> $past(owned_bad, 2));

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !result_vld_o |-> $stable(result_o));

endmodule

bind adc_digital_corr adc_digital_corr_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .smp_strobe_i  (smp_strobe_i),
    .stage_codes_i (stage_codes_i),
    .result_o      (result_o),
    .result_vld_o  (result_vld_o),
    .code_err_o    (code_err_o)
);

// File: tb/adc_digital_corr_tb.sv
`timescale 1ns/1ps
module adc_digital_corr_tb;

    localparam int NS   = 9;
    localparam int OW   = NS + 1;
    localparam int LATS = NS + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          strobe = 1'b0;
    logic [2*NS-1:0] codes = '0;
    logic [OW-1:0] result;
    logic          vld;
    logic          err;

    int n_chk = 0;
    int n_err = 0;
    int slot = 16;
    bit            q_on  [16];
    int            q_exp [16];
    logic [2*NS-1:0] q_code[16];
    int    last_res = 0;
    bit    exp_err  = 1'b0;
    string val_req  = "R2";
    string vld_req  = "R3";
    string err_req  = "R7";

    always #10 clk = ~clk;

    adc_digital_corr #(.NUM_STAGES(NS)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .smp_strobe_i  (strobe),
        .stage_codes_i (codes),
        .result_o      (result),
        .result_vld_o  (vld),
        .code_err_o    (err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d (slot %0d)", req, act, exp, slot);
        end
    endtask

    // Split a value into stage decisions; pol picks among the redundant choices.
    function automatic logic [2*NS-1:0] split_value(input int v, input int pol);
        logic [2*NS-1:0] pk = '0;
        int r = v;
        for (int k = 0; k < NS - 1; k++) begin
            int w  = 1 << (NS - 1 - k);
            int lo = 3;
            int hi = -1;
            int c;
            for (int t = 0; t < 3; t++) begin
                if (r - t*w >= 0 && r - t*w <= 2*w - 1) begin
                    if (t < lo) lo = t;
                    hi = t;
                end
            end
            if (pol == 0)      c = lo;
            else if (pol == 1) c = hi;
            else               c = ((v >> k) & 1) ? hi : lo;
            pk[2*k +: 2] = 2'(c);
            r = r - c*w;
        end
        pk[2*(NS-1) +: 2] = 2'(r);
        return pk;
    endfunction

    function automatic int weigh(input logic [2*NS-1:0] pk);
        int s = 0;
        for (int k = 0; k < NS; k++) begin
            int c = int'(pk[2*k +: 2]);
            if (k < NS - 1 && c == 3) c = 2;
            s = s + (c << (NS - 1 - k));
        end
        return s;
    endfunction

    task automatic do_slot(input bit start, input int v, input int pol,
                           input int force_k, input int junk_mode);
        int idx = slot % 16;
        int src;
        bit pend = 1'b0;
        logic [1:0] lane;
        q_on[idx] = start;
        if (start) begin
            q_code[idx] = split_value(v, pol);
            if (force_k >= 0) q_code[idx][2*force_k +: 2] = 2'd3;
            q_exp[idx] = weigh(q_code[idx]);
        end
        for (int k = 0; k < NS; k++) begin
            src = (slot - k) % 16;
            if (q_on[src]) begin
                lane = q_code[src][2*k +: 2];
                if (k < NS - 1 && lane == 2'd3) pend = 1'b1;
            end else begin
                case (junk_mode)
                    0:       lane = 2'd0;
                    1:       lane = 2'd3;
                    default: lane = 2'((slot + k) % 3);
                endcase
            end
            codes[2*k +: 2] = lane;
        end
        strobe = start;
        @(posedge clk);
        @(negedge clk);
        src = (slot - (LATS - 1)) % 16;
        chk(vld == q_on[src], vld_req, int'(vld), int'(q_on[src]));
        if (q_on[src]) begin
            chk(int'(result) == q_exp[src], val_req, int'(result), q_exp[src]);
            last_res = q_exp[src];
        end else begin
            chk(int'(result) == last_res, "R9", int'(result), last_res);
        end
        chk(err == exp_err, err_req, int'(err), int'(exp_err));
        exp_err = exp_err | pend;
        slot++;
    endtask

    task automatic do_reset(input string req);
        rst = 1'b1;
        strobe = 1'b0;
        codes = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) q_on[i] = 1'b0;
        exp_err  = 1'b0;
        last_res = 0;
        chk(vld == 1'b0, req, int'(vld), 0);
        chk(result == '0, req, int'(result), 0);
        chk(err == 1'b0, req, int'(err), 0);
    endtask

    task automatic idle(input int n, input int junk_mode);
        for (int i = 0; i < n; i++) do_slot(1'b0, 0, 0, -1, junk_mode);
    endtask

    initial begin
        do_reset("R1");

        // R2: full sweep, lowest decisions, quiet lanes between samples
        val_req = "R2"; err_req = "R8";
        for (int v = 0; v < 1024; v++) begin
            do_slot(1'b1, v, 0, -1, 0);
            do_slot(1'b0, 0, 0, -1, 0);
        end
        idle(10, 0);

        // R4: rotating junk on unowned lanes must not leak into results
        val_req = "R4";
        for (int v = 3; v < 1024; v += 8) begin
            do_slot(1'b1, v, 2, -1, 2);
            do_slot(1'b0, 0, 0, -1, 2);
        end
        idle(10, 2);

        // R5 with R7: other decision patterns, code 3 on every unowned lane
        val_req = "R5"; err_req = "R7";
        for (int p = 1; p < 3; p++) begin
            for (int v = 0; v < 1024; v++) begin
                do_slot(1'b1, v, p, -1, 1);
                do_slot(1'b0, 0, 0, -1, 1);
            end
        end
        idle(10, 1);

        // R8: last stage at code 3 (value 3 and 1023) leaves the flag low
        val_req = "R8"; err_req = "R8";
        do_slot(1'b1, 3, 0, -1, 0);
        do_slot(1'b1, 1023, 0, -1, 0);
        idle(10, 0);
        chk(err == 1'b0, "R8", int'(err), 0);

        // R10: strobes in every slot
        val_req = "R10"; err_req = "R10";
        for (int i = 0; i < 40; i++) do_slot(1'b1, (i*37 + 5) % 1024, 2, -1, 2);
        idle(10, 2);

        // R6: forced illegal code in owned slots, counted as 2, flag sticky
        val_req = "R6"; err_req = "R6";
        do_slot(1'b1, 600, 0, 2, 0);
        do_slot(1'b0, 0, 0, -1, 0);
        do_slot(1'b1, 100, 0, 0, 0);
        idle(12, 0);
        chk(err == 1'b1, "R6", int'(err), 1);
        for (int v = 10; v < 20; v++) do_slot(1'b1, v, 1, -1, 0);
        idle(10, 0);

        // R11: reset with samples in flight
        vld_req = "R11"; val_req = "R11"; err_req = "R11";
        for (int i = 0; i < 4; i++) begin
            do_slot(1'b1, 200 + i, 0, -1, 0);
            do_slot(1'b0, 0, 0, -1, 0);
        end
        do_reset("R11");
        idle(14, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL R3: watchdog expired, got 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule